// File: doc/BRIEF.md
# Interrupt Cycle and I/O Flag Controller

This block is the device-side control section of a small accumulator machine. It holds one character register for each direction, together with a ready flag for each. It decodes the six register-reference I/O instructions. When a device flag is raised while interrupts are enabled, it runs the three-step interrupt cycle, which parks the return address in memory and sends execution to location 1.

The sequencer supplies one-hot timing steps and the decoded opcode line. The block returns strobes for the program counter, the accumulator and the sequence counter, plus a write port into main memory. The sequencer watches `irq_cycle`: when it is high, the sequencer runs steps T0 to T2 as the interrupt cycle in place of a fetch. Input devices deliver a character with `in_valid`. Output devices report completion with `out_done` and are started by `out_start`.

Top module: `io_intr_ctrl`

## Requirements
- R1: After reset, `in_flag`, `out_flag`, `intr_en` and `irq_cycle` are 0, and `ac_load`, `pc_inc`, `pc_clr`, `sc_clr` and `mem_we` are 0 while no step is active.
- R2: A cycle with `in_valid` high loads `in_char` into the input register and sets `in_flag`. A cycle with `out_done` high sets `out_flag`. If a device sets a flag in the same cycle as an instruction clears it, the flag ends up set.
- R3: An I/O instruction acts only in a cycle with `d7`=1, `ir[15]`=1 and `t_step[3]`=1. In that cycle `sc_clr` is 1. Without all three, the instruction bits have no effect on flags, strobes or `intr_en`.
- R4: Input (`ir[11]`): `ac_load` is 1 and `ac_char` shows the input register. `in_flag` is 0 after the edge.
- R5: Output (`ir[10]`): after the edge, `out_char` holds the low byte of `ac_low`, `out_flag` is 0, and `out_start` is 1 for exactly one cycle.
- R6: Skip on input (`ir[9]`) and skip on output (`ir[8]`): `pc_inc` is 1 in the execute cycle exactly when `in_flag` or `out_flag` respectively is 1. Neither skip changes the flags.
- R7: `ir[7]` sets `intr_en` and `ir[6]` clears it, effective after the execute edge.
- R8: `irq_cycle` becomes 1 at an edge where none of T0, T1 or T2 is active, `intr_en` is 1, and `in_flag` or `out_flag` is 1. It never becomes 1 while `intr_en` is 0.
- R9: With `irq_cycle`=1, the interrupt cycle runs in three steps. At T0 the block captures `pc_in`. At T1 it asserts `mem_we` with `mem_addr`=0 and `mem_wdata` equal to the captured value, and asserts `pc_clr`. At T2 it asserts `pc_inc` and `sc_clr`, and after that edge `intr_en` and `irq_cycle` are 0.
- R10: After a full interrupt cycle, PC equals 1 and memory word 0 holds the address of the instruction after the interrupted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_step | input | NT (8) | One-hot timing steps T0.. from the sequencer |
| d7 | input | 1 | Decoded opcode line 7 |
| ir | input | IR_W (16) | Instruction register; bit 15 is the indirect bit |
| ac_low | input | CHAR_W (8) | Low byte of the accumulator |
| pc_in | input | ADDR_W (12) | Current program counter |
| in_valid | input | 1 | Input device delivers a character |
| in_char | input | CHAR_W (8) | Character from the input device |
| out_done | input | 1 | Output device finished its transfer |
| ac_load | output | 1 | Load `ac_char` into the accumulator low byte |
| ac_char | output | CHAR_W (8) | Input register contents |
| pc_inc | output | 1 | Increment PC at this edge |
| pc_clr | output | 1 | Clear PC at this edge |
| sc_clr | output | 1 | Clear the sequence counter at this edge |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W (12) | Memory write address |
| mem_wdata | output | DATA_W (16) | Memory write data (zero-extended PC) |
| out_start | output | 1 | One-cycle start strobe to the output device |
| out_char | output | CHAR_W (8) | Output register contents |
| in_flag | output | 1 | Input ready flag |
| out_flag | output | 1 | Output ready flag |
| intr_en | output | 1 | Interrupt enable |
| irq_cycle | output | 1 | Interrupt cycle pending or running |

## Verification
The assertions check the following on every cycle:
- the interrupt flag only rises with interrupts enabled and outside T0 to T2;
- a memory write always targets word 0 together with a PC clear;
- the interrupt cycle always exits with enable and pending both low;
- flag clears, the enable set and the output start strobe follow only their instructions;
- ungated instruction bits never raise a strobe.

Only the bench scenarios can show the following:
- the saved word is the next instruction's address rather than the current one;
- PC ends at exactly 1;
- a flag pending with interrupts disabled, held over many cycles, never starts the cycle;
- a device set wins over a same-cycle clear.

// File: rtl/io_intr_pkg.sv
package io_intr_pkg;

    localparam int OP_INP = 11;
    localparam int OP_OUT = 10;
    localparam int OP_SKI = 9;
    localparam int OP_SKO = 8;
    localparam int OP_ION = 7;
    localparam int OP_IOF = 6;

    typedef struct packed {
        logic inp;
        logic outp;
        logic ski;
        logic sko;
        logic ion;
        logic iof;
    } io_ops_t;

endpackage

// File: rtl/io_decode.sv
module io_decode
    import io_intr_pkg::*;
#(
    parameter int IR_W = 16
) (
    input  logic [IR_W-1:0] ir,
    input  logic            d7,
    input  logic            t3,
    output logic            io_exec,
    output io_ops_t         ops
);
    localparam int IND_BIT = IR_W - 1;

    logic unused_ir_bits;
    assign unused_ir_bits = ^{ir[IND_BIT-1:OP_INP+1], ir[OP_IOF-1:0]};

    always_comb begin
        io_exec  = d7 & ir[IND_BIT] & t3;
        ops.inp  = io_exec & ir[OP_INP];
        ops.outp = io_exec & ir[OP_OUT];
        ops.ski  = io_exec & ir[OP_SKI];
        ops.sko  = io_exec & ir[OP_SKO];
        ops.ion  = io_exec & ir[OP_ION];
        ops.iof  = io_exec & ir[OP_IOF];
    end
endmodule

// File: rtl/io_flag_unit.sv
module io_flag_unit
    import io_intr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              out_done,
    input  logic [CHAR_W-1:0] ac_low,
    input  io_ops_t           ops,
    output logic [CHAR_W-1:0] inpr,
    output logic [CHAR_W-1:0] outr,
    output logic              fgi,
    output logic              fgo,
    output logic              start
);
    typedef struct packed {
        logic [CHAR_W-1:0] inpr;
        logic [CHAR_W-1:0] outr;
        logic              fgi;
        logic              fgo;
        logic              start;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (ops.inp) st_d.fgi = 1'b0;
        if (ops.outp) begin
            st_d.outr  = ac_low;
            st_d.fgo   = 1'b0;
            st_d.start = 1'b1;
        end
        // device events win over an instruction clear in the same cycle
        if (in_valid) begin
            st_d.inpr = in_char;
            st_d.fgi  = 1'b1;
        end
        if (out_done) st_d.fgo = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inpr  = st_q.inpr;
    assign outr  = st_q.outr;
    assign fgi   = st_q.fgi;
    assign fgo   = st_q.fgo;
    assign start = st_q.start;
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import io_intr_pkg::*;
#(
    parameter int NT     = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT-1:0]     t_step,
    input  io_ops_t           ops,
    input  logic              fgi,
    input  logic              fgo,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              ien,
    output logic              r,
    output logic              mem_we,
    output logic [ADDR_W-1:0] ar,
    output logic [ADDR_W-1:0] tr,
    output logic              pc_clr,
    output logic              pc_inc,
    output logic              sc_clr
);
    typedef struct packed {
        logic              ien;
        logic              r;
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] tr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    fetch_win;
    logic    unused_steps;

    assign unused_steps = ^t_step[NT-1:3];

    always_comb begin
        fetch_win = t_step[0] | t_step[1] | t_step[2];
        st_d      = st_q;
        mem_we    = 1'b0;
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        sc_clr    = 1'b0;

        if (ops.ion) st_d.ien = 1'b1;
        if (ops.iof) st_d.ien = 1'b0;

        if (!fetch_win && st_q.ien && (fgi || fgo)) st_d.r = 1'b1;

        if (st_q.r) begin
            if (t_step[0]) begin
                st_d.ar = '0;
                st_d.tr = pc_in;
            end
            if (t_step[1]) begin
                mem_we = 1'b1;
                pc_clr = 1'b1;
            end
            if (t_step[2]) begin
                pc_inc   = 1'b1;
                sc_clr   = 1'b1;
                st_d.ien = 1'b0;
                st_d.r   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien = st_q.ien;
    assign r   = st_q.r;
    assign ar  = st_q.ar;
    assign tr  = st_q.tr;
endmodule

// File: rtl/io_intr_ctrl.sv
module io_intr_ctrl
    import io_intr_pkg::*;
#(
    parameter int NT     = 8,
    parameter int IR_W   = 16,
    parameter int CHAR_W = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT-1:0]     t_step,
    input  logic              d7,
    input  logic [IR_W-1:0]   ir,
    input  logic [CHAR_W-1:0] ac_low,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              out_done,
    output logic              ac_load,
    output logic [CHAR_W-1:0] ac_char,
    output logic              pc_inc,
    output logic              pc_clr,
    output logic              sc_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              out_start,
    output logic [CHAR_W-1:0] out_char,
    output logic              in_flag,
    output logic              out_flag,
    output logic              intr_en,
    output logic              irq_cycle
);
    localparam int PAD_W = DATA_W - ADDR_W;

    io_ops_t           ops;
    logic              io_exec;
    logic              seq_inc, seq_sc;
    logic [ADDR_W-1:0] tr;

    io_decode #(.IR_W(IR_W)) u_dec (
        .ir      (ir),
        .d7      (d7),
        .t3      (t_step[3]),
        .io_exec (io_exec),
        .ops     (ops)
    );

    io_flag_unit #(.CHAR_W(CHAR_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_char  (in_char),
        .out_done (out_done),
        .ac_low   (ac_low),
        .ops      (ops),
        .inpr     (ac_char),
        .outr     (out_char),
        .fgi      (in_flag),
        .fgo      (out_flag),
        .start    (out_start)
    );

    intr_seq #(.NT(NT), .ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .t_step (t_step),
        .ops    (ops),
        .fgi    (in_flag),
        .fgo    (out_flag),
        .pc_in  (pc_in),
        .ien    (intr_en),
        .r      (irq_cycle),
        .mem_we (mem_we),
        .ar     (mem_addr),
        .tr     (tr),
        .pc_clr (pc_clr),
        .pc_inc (seq_inc),
        .sc_clr (seq_sc)
    );

    always_comb begin
        ac_load   = ops.inp;
        pc_inc    = seq_inc | (ops.ski & in_flag) | (ops.sko & out_flag);
        sc_clr    = seq_sc | io_exec;
        mem_wdata = {{PAD_W{1'b0}}, tr};
    end
endmodule

// File: rtl/io_intr_chk.sv
module io_intr_chk #(
    parameter int NT     = 8,
    parameter int IR_W   = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NT-1:0]     t_step,
    input logic              d7,
    input logic [IR_W-1:0]   ir,
    input logic              in_valid,
    input logic              ac_load,
    input logic              pc_clr,
    input logic              sc_clr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_start,
    input logic              in_flag,
    input logic              intr_en,
    input logic              irq_cycle
);
    // R8
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cycle) |-> $past(intr_en));
    // R8
    a_r8_not_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cycle) |-> !$past(t_step[0] || t_step[1] || t_step[2]));
    // R9
    a_r9_save_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == '0 && pc_clr && irq_cycle));
    // R9
    a_r9_cycle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cycle && t_step[2]) |=> (!intr_en && !irq_cycle));
    // R4
    a_r4_input_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_load && !in_valid) |=> !in_flag);
    // R7
    a_r7_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (d7 && ir[IR_W-1] && t_step[3] && ir[7] && !ir[6]) |=> intr_en);
    // R5
    a_r5_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> $past(d7 && ir[IR_W-1] && t_step[3] && ir[10]));
    // R3
    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((!d7 || !ir[IR_W-1]) && !irq_cycle) |-> (!sc_clr && !ac_load));
endmodule

bind io_intr_ctrl io_intr_chk #(.NT(NT), .IR_W(IR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_step    (t_step),
    .d7        (d7),
    .ir        (ir),
    .in_valid  (in_valid),
    .ac_load   (ac_load),
    .pc_clr    (pc_clr),
    .sc_clr    (sc_clr),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .out_start (out_start),
    .in_flag   (in_flag),
    .intr_en   (intr_en),
    .irq_cycle (irq_cycle)
);

// File: tb/test_io_intr_ctrl.sv
module test_io_intr_ctrl;
    localparam int NT = 8, IR_W = 16, CHAR_W = 8, ADDR_W = 12, DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic [NT-1:0] t_step;
    logic d7;
    logic [IR_W-1:0] ir;
    logic [CHAR_W-1:0] ac_low, in_char;
    logic [ADDR_W-1:0] pc_in;
    logic in_valid, out_done;
    logic ac_load, pc_inc, pc_clr, sc_clr, mem_we, out_start;
    logic [CHAR_W-1:0] ac_char, out_char;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic in_flag, out_flag, intr_en, irq_cycle;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [ADDR_W-1:0] pc_model;
    logic [DATA_W-1:0] mem0;

    always #10 clk = ~clk;

    io_intr_ctrl i_io_intr_ctrl (.*);

    assign pc_in = pc_model;

    always @(posedge clk) begin
        if (pc_clr) pc_model <= '0;
        else if (pc_inc) pc_model <= pc_model + 1'b1;
        if (mem_we && mem_addr == '0) mem0 <= mem_wdata;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        t_step = '0; d7 = 1'b0; ir = '0; in_valid = 1'b0; out_done = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; t_step = '0; d7 = 1'b0; ir = '0;
        in_valid = 1'b0; out_done = 1'b0; in_char = '0; ac_low = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic give_char(input logic [CHAR_W-1:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_char = c;
        idle();
    endtask

    task automatic give_done();
        @(negedge clk);
        out_done = 1'b1;
        idle();
    endtask

    // drive an I/O instruction at T3; returns before the edge, comb outputs settled
    task automatic exec_at_t3(input int bit_idx, input logic dd7, input logic ind);
        @(negedge clk);
        d7 = dd7; ir = '0; ir[IR_W-1] = ind; ir[bit_idx] = 1'b1;
        t_step = '0; t_step[3] = 1'b1;
        #1;
    endtask

    task automatic step_t(input int k);
        @(negedge clk);
        d7 = 1'b0; ir = '0; t_step = '0; t_step[k] = 1'b1;
        #1;
    endtask

    typedef struct packed {
        logic [3:0] op;
        logic pi, po, pe;
        logic e_inc, e_ld, e_in, e_out, e_ien;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'd11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd9,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd8,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd6,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        pc_model = '0;
        mem0 = '0;
        do_reset();
        idle();
        // R1 reset state
        check("R1 in_flag", in_flag, 0);
        check("R1 out_flag", out_flag, 0);
        check("R1 intr_en", intr_en, 0);
        check("R1 irq_cycle", irq_cycle, 0);
        check("R1 strobes", {ac_load, pc_inc, pc_clr, sc_clr, mem_we}, 0);

        // table of I/O instructions (R4 R5 R6 R7 R3)
        for (int i = 0; i < 8; i++) begin
            do_reset();
            idle();
            if (VEC[i].pe) begin
                exec_at_t3(7, 1'b1, 1'b1);
                idle();
            end
            if (VEC[i].pi) give_char(8'h3C);
            if (VEC[i].po) give_done();
            exec_at_t3(VEC[i].op, 1'b1, 1'b1);
            check($sformatf("R6 pc_inc op%0d", VEC[i].op), pc_inc, VEC[i].e_inc);
            check($sformatf("R4 ac_load op%0d", VEC[i].op), ac_load, VEC[i].e_ld);
            check($sformatf("R3 sc_clr op%0d", VEC[i].op), sc_clr, 1);
            idle();
            check($sformatf("R4 in_flag op%0d", VEC[i].op), in_flag, VEC[i].e_in);
            check($sformatf("R5 out_flag op%0d", VEC[i].op), out_flag, VEC[i].e_out);
            check($sformatf("R7 intr_en op%0d", VEC[i].op), intr_en, VEC[i].e_ien);
        end

        // R2 device loads and set-wins-over-clear
        do_reset();
        give_char(8'h5A);
        check("R2 in_flag set", in_flag, 1);
        check("R4 ac_char", ac_char, 8'h5A);
        exec_at_t3(11, 1'b1, 1'b1);
        in_valid = 1'b1; in_char = 8'h77;
        #1;
        check("R4 ac_char old", ac_char, 8'h5A);
        idle();
        check("R2 set wins", in_flag, 1);
        check("R2 new char", ac_char, 8'h77);
        give_done();
        check("R2 out_flag set", out_flag, 1);

        // R5 output register and one-cycle start
        ac_low = 8'hC3;
        exec_at_t3(10, 1'b1, 1'b1);
        idle();
        check("R5 out_char", out_char, 8'hC3);
        check("R5 out_start", out_start, 1);
        idle();
        check("R5 out_start one cycle", out_start, 0);

        // R3 gating: missing d7, missing indirect bit, wrong step
        do_reset();
        exec_at_t3(7, 1'b0, 1'b1);
        check("R3 no d7 sc_clr", sc_clr, 0);
        idle();
        check("R3 no d7 ien", intr_en, 0);
        exec_at_t3(7, 1'b1, 1'b0);
        idle();
        check("R3 no I ien", intr_en, 0);
        @(negedge clk);
        d7 = 1'b1; ir = 16'h8080; t_step = '0; t_step[4] = 1'b1;
        idle();
        check("R3 wrong step ien", intr_en, 0);

        // R8 pending flags with IEN=0 never start the cycle
        give_char(8'h11);
        give_done();
        for (int k = 3; k < 8; k++) step_t(k);
        idle();
        check("R8 disabled no irq", irq_cycle, 0);

        // enable; hold fetch steps, then a later step
        exec_at_t3(7, 1'b1, 1'b1);
        step_t(0);
        step_t(1);
        step_t(2);
        check("R8 no set in fetch", irq_cycle, 0);
        step_t(4);
        idle();
        check("R8 irq set", irq_cycle, 1);

        // R9 R10 interrupt cycle; interrupted instruction at 0x255, PC already 0x256
        @(negedge clk);
        pc_model = 12'h256;
        step_t(0);
        step_t(1);
        check("R9 mem_we", mem_we, 1);
        check("R9 mem_addr", mem_addr, 0);
        check("R9 mem_wdata", mem_wdata, 16'h0256);
        check("R9 pc_clr", pc_clr, 1);
        step_t(2);
        check("R9 pc_inc", pc_inc, 1);
        check("R9 sc_clr", sc_clr, 1);
        idle();
        check("R9 ien cleared", intr_en, 0);
        check("R9 irq cleared", irq_cycle, 0);
        check("R10 pc is 1", pc_model, 1);
        check("R10 mem0 next addr", mem0, 16'h0256);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule